// File: doc/BRIEF.md
# Transaction Status Controller

This block is the per-processor control unit for hardware transactions. It keeps two flags: one saying a transaction is in progress, and one saying that transaction is still live rather than aborted. It accepts one transactional instruction at a time: a shared load, an exclusive load, a tentative store, a status check, a commit and an abort. For each one it decides whether a bus request is needed, signals the transactional cache with one-cycle commit, abort and fill strobes, and returns a status bit to the processor with a one-cycle done pulse.

There is no begin instruction. The first memory-type transactional instruction marks the transaction active. A refused bus request, an interrupt or a transactional cache overflow kills a live transaction at any time. The processor learns this only when it later asks for status or tries to commit. The cache storage and the bus arbitration are outside this block. The block sees a hit indication from the cache and a response, with a refusal flag, from the bus.

Top module: `txn_status_ctrl`

## Requirements
- R1: After synchronous reset, txn_active is 0, txn_live is 1, op_ready is 1, and done, all strobes and bus_req_valid are 0.
- R2: Opcode encoding on op_code: 0 shared load, 1 exclusive load, 2 store, 3 status check, 4 commit, 5 abort. A load or store accepted while live with cache_hit=1 sets txn_active. One cycle later it gives done=1 with status_bit=1 and makes no bus request.
- R3: A load or store accepted while live with cache_hit=0 raises bus_req_valid on the next cycle, carrying op_addr. bus_req_rfo is 0 for a shared load and 1 for an exclusive load or a store. The request is held and op_ready stays 0 until bus_resp_valid, and an instruction offered meanwhile has no effect.
- R4: A non-refused response (bus_resp_busy=0) with the transaction still live gives done, status_bit=1 and fill_strobe on the next cycle. fill_reserved is 1 exactly when the request had bus_req_rfo=1.
- R5: A refused response (bus_resp_busy=1) gives done with status_bit=0, an abort_strobe pulse and no fill, and leaves txn_live=0 with txn_active=1. A response to a transaction that was killed while it waited gives done, status_bit=0, no fill and no second abort strobe.
- R6: While txn_live is 0, a load or store makes no bus request and completes one cycle later with done and status_bit=0.
- R7: A status check returns txn_live in status_bit. If the check returns 0, it clears txn_active and sets txn_live. If it returns 1, the flags are unchanged.
- R8: A commit while live pulses commit_strobe, returns status_bit=1, and leaves txn_active=0 and txn_live=1.
- R9: A commit while not live pulses abort_strobe instead of commit_strobe, returns status_bit=0, and leaves txn_active=0 and txn_live=1.
- R10: An abort pulses abort_strobe, returns status_bit=0, and leaves txn_active=0 and txn_live=1.
- R11: irq or tc_overflow high while a transaction is active and live clears txn_live and pulses abort_strobe for one cycle. With no transaction active, they change nothing.
- R12: An irq in the same cycle as an accepted commit makes the commit fail, as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction offered |
| op_code | input | 3 | Instruction opcode (R2 encoding) |
| op_addr | input | ADDR_W | Word address of a load or store |
| op_ready | output | 1 | Instruction can be accepted this cycle |
| cache_hit | input | 1 | Transactional cache holds a usable entry for op_addr |
| bus_req_valid | output | 1 | Transactional bus request outstanding |
| bus_req_rfo | output | 1 | 1 = ownership request, 0 = shared request |
| bus_req_addr | output | ADDR_W | Address of the outstanding request |
| bus_resp_valid | input | 1 | Bus response for the outstanding request |
| bus_resp_busy | input | 1 | Response is a refusal |
| irq | input | 1 | Interrupt |
| tc_overflow | input | 1 | Transactional cache overflow |
| done | output | 1 | Instruction complete pulse |
| status_bit | output | 1 | Result returned with done |
| commit_strobe | output | 1 | Make tentative lines permanent |
| abort_strobe | output | 1 | Discard tentative lines |
| fill_strobe | output | 1 | Install the line that was fetched |
| fill_reserved | output | 1 | Installed line is held exclusively |
| txn_active | output | 1 | Transaction in progress |
| txn_live | output | 1 | Transaction not aborted |

## Verification
The critical overlap is an interrupt arriving in the same cycle as a commit. The bench raises irq at the same clock edge that accepts the commit and expects an abort strobe, a zero status and no commit strobe. A second overlap is an interrupt that kills a transaction while its bus request is pending. The bench expects the abort strobe at the interrupt, then a clean done with status zero and no fill when the ordinary response arrives. A refused response is tested the same way, to show that only one abort pulse is produced.

// File: rtl/txn_pkg.sv
package txn_pkg;
  typedef enum logic [2:0] {
    OP_LOAD      = 3'd0,
    OP_LOAD_EXCL = 3'd1,
    OP_STORE     = 3'd2,
    OP_CHECK     = 3'd3,
    OP_COMMIT    = 3'd4,
    OP_ABORT     = 3'd5,
    OP_RSVD6     = 3'd6,
    OP_RSVD7     = 3'd7
  } txn_op_e;

  typedef enum logic {
    REQ_SHARED = 1'b0,
    REQ_OWN    = 1'b1
  } req_kind_e;
endpackage

// File: rtl/txn_flags.sv
module txn_flags (
  input  logic clk,
  input  logic rst,
  input  logic set_active,
  input  logic end_txn,
  input  logic kill,
  output logic active,
  output logic live
);
  // Ending a transaction outranks a kill in the same cycle: the
  // instruction that ends it has already folded the kill into its result.
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      live   <= 1'b1;
    end else if (end_txn) begin
      active <= 1'b0;
      live   <= 1'b1;
    end else begin
      if (kill)       live   <= 1'b0;
      if (set_active) active <= 1'b1;
    end
  end

  // R11: a kill with no ending instruction leaves the flag dead
  a_r11_kill_sticks: assert property (@(posedge clk) disable iff (rst)
    (kill && !end_txn) |=> !live);
endmodule

// File: rtl/txn_bus_port.sv
module txn_bus_port
  import txn_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  req_kind_e         kind_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              resp_valid,
  output logic              pending,
  output req_kind_e         kind,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      kind    <= REQ_SHARED;
      addr    <= '0;
    end else if (issue) begin
      pending <= 1'b1;
      kind    <= kind_in;
      addr    <= addr_in;
    end else if (resp_valid && pending) begin
      pending <= 1'b0;
    end
  end

  // R3: the sequencer never issues on top of an outstanding request
  a_r3_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    pending |-> !issue);
endmodule

// File: rtl/txn_status_ctrl.sv
module txn_status_ctrl
  import txn_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              op_ready,
  input  logic              cache_hit,
  output logic              bus_req_valid,
  output logic              bus_req_rfo,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_resp_valid,
  input  logic              bus_resp_busy,
  input  logic              irq,
  input  logic              tc_overflow,
  output logic              done,
  output logic              status_bit,
  output logic              commit_strobe,
  output logic              abort_strobe,
  output logic              fill_strobe,
  output logic              fill_reserved,
  output logic              txn_active,
  output logic              txn_live
);
  txn_op_e   op;
  logic      pending, acc, is_mem, irq_any, kill, kill_all, live_now;
  logic      issue, resp, resp_ok, end_txn;
  logic      nxt_status, nxt_abort, nxt_commit;
  req_kind_e req_kind, held_kind;

  assign op       = txn_op_e'(op_code);
  assign op_ready = !pending;
  assign acc      = op_valid && !pending;
  assign is_mem   = acc && (op == OP_LOAD || op == OP_LOAD_EXCL || op == OP_STORE);
  assign irq_any  = irq || tc_overflow;
  // An abort source counts only against a live transaction that exists
  // or is being started by this very instruction.
  assign kill     = irq_any && txn_live && (txn_active || is_mem);
  assign live_now = txn_live && !kill;
  assign resp     = pending && bus_resp_valid;
  assign resp_ok  = resp && live_now && !bus_resp_busy;
  assign kill_all = kill || (resp && bus_resp_busy && txn_live);
  assign issue    = is_mem && live_now && !cache_hit;
  assign req_kind = (op == OP_LOAD) ? REQ_SHARED : REQ_OWN;
  assign end_txn  = acc && (op == OP_COMMIT || op == OP_ABORT ||
                            (op == OP_CHECK && !live_now));

  always_comb begin
    nxt_status = 1'b0;
    if (resp) nxt_status = resp_ok;
    else if (acc && (is_mem || op == OP_CHECK || op == OP_COMMIT)) nxt_status = live_now;
  end

  assign nxt_commit = acc && (op == OP_COMMIT) && live_now;
  assign nxt_abort  = kill_all || (acc && op == OP_ABORT) ||
                      (acc && op == OP_COMMIT && !live_now);

  txn_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .set_active (is_mem),
    .end_txn    (end_txn),
    .kill       (kill_all),
    .active     (txn_active),
    .live       (txn_live)
  );

  txn_bus_port #(.ADDR_W(ADDR_W)) u_bus (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .kind_in    (req_kind),
    .addr_in    (op_addr),
    .resp_valid (bus_resp_valid),
    .pending    (pending),
    .kind       (held_kind),
    .addr       (bus_req_addr)
  );

  assign bus_req_valid = pending;
  assign bus_req_rfo   = (held_kind == REQ_OWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      done          <= 1'b0;
      status_bit    <= 1'b0;
      commit_strobe <= 1'b0;
      abort_strobe  <= 1'b0;
      fill_strobe   <= 1'b0;
      fill_reserved <= 1'b0;
    end else begin
      done          <= (acc && !issue) || resp;
      status_bit    <= nxt_status;
      commit_strobe <= nxt_commit;
      abort_strobe  <= nxt_abort;
      fill_strobe   <= resp_ok;
      fill_reserved <= resp_ok && (held_kind == REQ_OWN);
    end
  end

  // R8: a commit strobe never meets an abort strobe and closes the transaction
  a_r8_commit_closes: assert property (@(posedge clk) disable iff (rst)
    commit_strobe |-> (!abort_strobe && !txn_active && txn_live && status_bit));
  // R6: a new bus request is only launched by a live transaction
  a_r6_no_req_when_dead: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req_valid) |-> $past(txn_live));
  // R3: an unanswered request holds its address and produces no done
  a_r3_hold_request: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && !bus_resp_valid) |=> (bus_req_valid && $stable(bus_req_addr) && !done));
  // R4: a fill only accompanies a successful completion of a live transaction
  a_r4_fill_live: assert property (@(posedge clk) disable iff (rst)
    fill_strobe |-> (done && status_bit && txn_live && txn_active));
endmodule

// File: tb/test_txn_status_ctrl.sv
module test_txn_status_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [31:0] op_addr = 32'd0;
  logic        op_ready;
  logic        cache_hit = 1'b0;
  logic        bus_req_valid, bus_req_rfo;
  logic [31:0] bus_req_addr;
  logic        bus_resp_valid = 1'b0, bus_resp_busy = 1'b0;
  logic        irq = 1'b0, tc_overflow = 1'b0;
  logic        done, status_bit, commit_strobe, abort_strobe;
  logic        fill_strobe, fill_reserved, txn_active, txn_live;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  txn_status_ctrl #(.ADDR_W(32)) i_txn_status_ctrl (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_ready(op_ready), .cache_hit(cache_hit),
    .bus_req_valid(bus_req_valid), .bus_req_rfo(bus_req_rfo),
    .bus_req_addr(bus_req_addr), .bus_resp_valid(bus_resp_valid),
    .bus_resp_busy(bus_resp_busy), .irq(irq), .tc_overflow(tc_overflow),
    .done(done), .status_bit(status_bit), .commit_strobe(commit_strobe),
    .abort_strobe(abort_strobe), .fill_strobe(fill_strobe),
    .fill_reserved(fill_reserved), .txn_active(txn_active), .txn_live(txn_live)
  );

  localparam logic [2:0] LD = 3'd0, LDX = 3'd1, STR = 3'd2, CHK = 3'd3, CMT = 3'd4, ABT = 3'd5;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Offer one instruction for one edge; outputs are sampled 1 ns after it.
  task automatic send(input logic [2:0] code, input logic [31:0] addr, input logic hit, input logic with_irq);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_addr = addr; cache_hit = hit; irq = with_irq;
    @(posedge clk); #1;
    op_valid = 1'b0; cache_hit = 1'b0; irq = 1'b0;
  endtask

  task automatic respond(input logic busy);
    @(negedge clk);
    bus_resp_valid = 1'b1; bus_resp_busy = busy;
    @(posedge clk); #1;
    bus_resp_valid = 1'b0; bus_resp_busy = 1'b0;
  endtask

  task automatic pulse_abort_src(input logic use_ovf);
    @(negedge clk);
    if (use_ovf) tc_overflow = 1'b1; else irq = 1'b1;
    @(posedge clk); #1;
    tc_overflow = 1'b0; irq = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "txn_active", txn_active, 0);
    chk("R1", "txn_live", txn_live, 1);
    chk("R1", "op_ready", op_ready, 1);
    chk("R1", "outputs", {done, commit_strobe, abort_strobe, fill_strobe, bus_req_valid}, 0);
  endtask

  task automatic t_hit_commit;
    send(LD, 32'h10, 1'b1, 1'b0);
    chk("R2", "done", done, 1);
    chk("R2", "status_bit", status_bit, 1);
    chk("R2", "bus_req_valid", bus_req_valid, 0);
    chk("R2", "txn_active", txn_active, 1);
    send(CHK, 32'h0, 1'b0, 1'b0);
    chk("R7", "live check status", status_bit, 1);
    chk("R7", "live check keeps active", txn_active, 1);
    send(CMT, 32'h0, 1'b0, 1'b0);
    chk("R8", "commit_strobe", commit_strobe, 1);
    chk("R8", "abort_strobe", abort_strobe, 0);
    chk("R8", "status_bit", status_bit, 1);
    chk("R8", "flags", {txn_active, txn_live}, 2'b01);
    @(posedge clk); #1;
    chk("R8", "strobe one cycle", commit_strobe, 0);
  endtask

  task automatic t_miss_read;
    send(LD, 32'h40, 1'b0, 1'b0);
    chk("R3", "done while waiting", done, 0);
    chk("R3", "bus_req_valid", bus_req_valid, 1);
    chk("R3", "bus_req_rfo", bus_req_rfo, 0);
    chk("R3", "bus_req_addr", bus_req_addr, 32'h40);
    chk("R3", "op_ready", op_ready, 0);
    send(ABT, 32'h0, 1'b0, 1'b0);
    chk("R3", "blocked abort strobe", abort_strobe, 0);
    chk("R3", "blocked abort active", txn_active, 1);
    chk("R3", "still waiting", bus_req_valid, 1);
    respond(1'b0);
    chk("R4", "done", done, 1);
    chk("R4", "status_bit", status_bit, 1);
    chk("R4", "fill_strobe", fill_strobe, 1);
    chk("R4", "fill_reserved", fill_reserved, 0);
    chk("R4", "request dropped", bus_req_valid, 0);
    send(CMT, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_miss_own;
    send(LDX, 32'h80, 1'b0, 1'b0);
    chk("R3", "excl load rfo", bus_req_rfo, 1);
    respond(1'b0);
    chk("R4", "excl fill_reserved", fill_reserved, 1);
    send(STR, 32'hC4, 1'b0, 1'b0);
    chk("R3", "store rfo", bus_req_rfo, 1);
    chk("R3", "store addr", bus_req_addr, 32'hC4);
    respond(1'b0);
    chk("R4", "store fill", {fill_strobe, fill_reserved, status_bit}, 3'b111);
    send(CMT, 32'h0, 1'b0, 1'b0);
    chk("R8", "commit after fills", commit_strobe, 1);
  endtask

  task automatic t_busy;
    send(LD, 32'h100, 1'b0, 1'b0);
    respond(1'b1);
    chk("R5", "done", done, 1);
    chk("R5", "status_bit", status_bit, 0);
    chk("R5", "abort_strobe", abort_strobe, 1);
    chk("R5", "fill_strobe", fill_strobe, 0);
    chk("R5", "flags", {txn_active, txn_live}, 2'b10);
    send(LDX, 32'h104, 1'b0, 1'b0);
    chk("R6", "dead done", done, 1);
    chk("R6", "dead status", status_bit, 0);
    chk("R6", "no request", bus_req_valid, 0);
    send(CHK, 32'h0, 1'b0, 1'b0);
    chk("R7", "dead check status", status_bit, 0);
    chk("R7", "dead check flags", {txn_active, txn_live}, 2'b01);
    send(CHK, 32'h0, 1'b0, 1'b0);
    chk("R7", "idle check status", status_bit, 1);
  endtask

  task automatic t_commit_dead;
    send(LD, 32'h200, 1'b1, 1'b0);
    pulse_abort_src(1'b0);
    chk("R11", "irq abort_strobe", abort_strobe, 1);
    chk("R11", "irq live", txn_live, 0);
    send(CMT, 32'h0, 1'b0, 1'b0);
    chk("R9", "commit_strobe", commit_strobe, 0);
    chk("R9", "abort_strobe", abort_strobe, 1);
    chk("R9", "status_bit", status_bit, 0);
    chk("R9", "flags", {txn_active, txn_live}, 2'b01);
  endtask

  task automatic t_idle_irq_and_overflow;
    pulse_abort_src(1'b0);
    chk("R11", "idle irq strobe", abort_strobe, 0);
    chk("R11", "idle irq flags", {txn_active, txn_live}, 2'b01);
    send(STR, 32'h300, 1'b1, 1'b0);
    pulse_abort_src(1'b1);
    chk("R11", "overflow strobe", abort_strobe, 1);
    chk("R11", "overflow live", txn_live, 0);
    @(posedge clk); #1;
    chk("R11", "strobe one cycle", abort_strobe, 0);
    send(ABT, 32'h0, 1'b0, 1'b0);
    chk("R10", "abort_strobe", abort_strobe, 1);
    chk("R10", "status_bit", status_bit, 0);
    chk("R10", "done", done, 1);
    chk("R10", "flags", {txn_active, txn_live}, 2'b01);
  endtask

  task automatic t_collide;
    send(LD, 32'h400, 1'b1, 1'b0);
    send(CMT, 32'h0, 1'b0, 1'b1);
    chk("R12", "commit_strobe", commit_strobe, 0);
    chk("R12", "abort_strobe", abort_strobe, 1);
    chk("R12", "status_bit", status_bit, 0);
    chk("R12", "flags", {txn_active, txn_live}, 2'b01);
  endtask

  task automatic t_irq_while_waiting;
    send(LDX, 32'h500, 1'b0, 1'b0);
    pulse_abort_src(1'b0);
    chk("R11", "wait irq strobe", abort_strobe, 1);
    chk("R11", "wait irq live", txn_live, 0);
    respond(1'b0);
    chk("R5", "late resp done", done, 1);
    chk("R5", "late resp status", status_bit, 0);
    chk("R5", "late resp no fill", fill_strobe, 0);
    chk("R5", "late resp no second abort", abort_strobe, 0);
    send(ABT, 32'h0, 1'b0, 1'b0);
    chk("R10", "abort after late resp", {txn_active, txn_live}, 2'b01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_hit_commit();
    t_miss_read();
    t_miss_own();
    t_busy();
    t_commit_dead();
    t_idle_irq_and_overflow();
    t_collide();
    t_irq_while_waiting();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule